// File: doc/BRIEF.md
# Test Access Port with Shared Debug Serial Pins

This block is a boundary-scan style test access port that is clocked by the test clock pin. It contains a sixteen-state controller that is steered by the mode-select pin, a 4-bit instruction register, a 1-bit bypass register and a stub boundary chain of parameterised length. The chain has no pad cells; it captures a fixed pattern so that its path can be observed from the serial pins. Serial data enters on the rising edge of the test clock. The serial output and its enable are retimed onto the falling edge.

A 3-bit mode code decides which function owns the serial pins. With code 000 the test port owns them. With code 001 the pins belong to a debug serial link. In that mode the data-in pin is forwarded to the debug engine, the debug engine's serial output is driven out on a dedicated pin, and the mode-select pin is passed on as a hardware breakpoint request. Every other mode code parks both functions.

The input pins are pulled high on the board, so an undriven pin reads as 1. Mode changes are quasi-static control, not a data stream, so there is no handshake at the edge of the block.

Top module: `jtag_dbg_port`

## Requirements
- R1: The controller moves only on rising test-clock edges, following the sixteen-state graph. From Run-Test/Idle, mode-select values 1,0,0 reach Shift-DR, and 1,1,0,0 reach Shift-IR.
- R2: Five consecutive rising edges with mode-select high reach Test-Logic-Reset from any state. Being in that state loads the bypass instruction (1111).
- R3: A low level on trst_n forces Test-Logic-Reset at once, without waiting for a clock edge. It also drops the output enable and loads the bypass instruction.
- R4: The instruction shifter captures 0001 in Capture-IR. It shifts out bit 0 first, and new data enters at bit 3. The shifted value becomes active on the rising edge that leaves Update-IR.
- R5: The bypass register captures 0 in Capture-DR. It then delays the data-in pin by one clock.
- R6: Instruction codes 0000 and 0010 select the 8-bit boundary chain, which captures 0xA5 and shifts out bit 0 first. Every other code, including 1111, selects bypass.
- R7: Registers shift only in their Shift state. Pause-DR keeps the chain contents, and shifting resumes from the same bit after Exit2.
- R8: The serial output and its enable change only on falling test-clock edges.
- R9: The output enable is high only in the low phase that follows a rising edge that left the controller in Shift-DR or Shift-IR.
- R10: With mode 001, the controller is held in Test-Logic-Reset and the output enable stays low. In this mode dbg_si follows the data-in pin, dbg_brk follows the mode-select pin, and pin_dso follows dbg_tx.
- R11: With mode 000, the debug outputs are idle: dbg_si is 1, dbg_brk is 0 and pin_dso is 1.
- R12: With any other mode code, the controller is held in Test-Logic-Reset, the output enable is low and the debug outputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| pin_tms | input | 1 | Mode-select pin, also the breakpoint line in debug mode |
| pin_tdi | input | 1 | Serial data-in pin |
| mode_sel | input | 3 | Pin-function code |
| dbg_tx | input | 1 | Serial output of the debug engine |
| pin_tdo | output | 1 | Serial test data out |
| pin_tdo_oe | output | 1 | Output enable for pin_tdo (low means high impedance) |
| pin_dso | output | 1 | Debug serial output pin |
| dbg_si | output | 1 | Debug serial input toward the debug engine |
| dbg_brk | output | 1 | Hardware breakpoint request |

## Verification
The bench checks that the enable rises half a clock after Shift-DR is entered; a design that drives it on the rising edge exposes a stale bit. It also stops in Pause-DR for several clocks, and a design that keeps shifting there loses chain bits when shifting resumes. It escapes from the middle of a shift with five high mode-select edges and pulls trst_n low between edges; a controller that misses either keeps the old instruction, and its next scan shows the boundary chain instead of bypass. Finally it switches the pin function while the controller is busy, and a design that does not hold the controller in reset comes back with a stale instruction or raises the enable while the pins belong to the debug link.

// File: rtl/tapdbg_pkg.sv
package tapdbg_pkg;

  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;

  localparam logic [2:0] MODE_TEST  = 3'b000;
  localparam logic [2:0] MODE_DEBUG = 3'b001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SDR, ST_CDR, ST_HDR, ST_E1D, ST_PDR, ST_E2D, ST_UDR,
    ST_SIR, ST_CIR, ST_HIR, ST_E1I, ST_PIR, ST_E2I, ST_UIR
  } tap_state_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      ST_TLR:  n = m ? ST_TLR : ST_RTI;
      ST_RTI:  n = m ? ST_SDR : ST_RTI;
      ST_SDR:  n = m ? ST_SIR : ST_CDR;
      ST_CDR:  n = m ? ST_E1D : ST_HDR;
      ST_HDR:  n = m ? ST_E1D : ST_HDR;
      ST_E1D:  n = m ? ST_UDR : ST_PDR;
      ST_PDR:  n = m ? ST_E2D : ST_PDR;
      ST_E2D:  n = m ? ST_UDR : ST_HDR;
      ST_UDR:  n = m ? ST_SDR : ST_RTI;
      ST_SIR:  n = m ? ST_TLR : ST_CIR;
      ST_CIR:  n = m ? ST_E1I : ST_HIR;
      ST_HIR:  n = m ? ST_E1I : ST_HIR;
      ST_E1I:  n = m ? ST_UIR : ST_PIR;
      ST_PIR:  n = m ? ST_E2I : ST_PIR;
      ST_E2I:  n = m ? ST_UIR : ST_HIR;
      ST_UIR:  n = m ? ST_SDR : ST_RTI;
      default: n = ST_TLR;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tapdbg_fsm.sv
module tapdbg_fsm
  import tapdbg_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tapdbg_ir.sv
module tapdbg_ir
  import tapdbg_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_shift,
  output logic [IR_W-1:0] ir_active,
  output logic            ir_so
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_shift <= IR_CAPTURE;
    end else if (state == ST_CIR) begin
      ir_shift <= IR_CAPTURE;
    end else if (state == ST_HIR) begin
      ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                 ir_active <= OP_BYPASS;
    else if (state == ST_TLR)   ir_active <= OP_BYPASS;
    else if (state == ST_UIR)   ir_active <= ir_shift;
  end

  assign ir_so = ir_shift[0];

endmodule

// File: rtl/tapdbg_dr.sv
module tapdbg_dr
  import tapdbg_pkg::*;
#(
  parameter int unsigned       BS_LEN = 8,
  parameter logic [BS_LEN-1:0] BS_CAP = 8'hA5
) (
  input  logic              tck,
  input  logic              rst_n,
  input  tap_state_e        state,
  input  logic [IR_W-1:0]   ir_active,
  input  logic              tdi,
  output logic              byp_q,
  output logic [BS_LEN-1:0] bs_q,
  output logic              dr_so
);

  logic sel_bs;
  logic do_shift;

  assign sel_bs   = (ir_active == OP_EXTEST) || (ir_active == OP_SAMPLE);
  assign do_shift = (state == ST_HDR);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                         byp_q <= 1'b0;
    else if (state == ST_CDR)           byp_q <= 1'b0;
    else if (do_shift && !sel_bs)       byp_q <= tdi;
  end

  generate
    if (BS_LEN == 1) begin : g_bs_single
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                             bs_q <= '0;
        else if (state == ST_CDR && sel_bs)     bs_q <= BS_CAP;
        else if (do_shift && sel_bs)            bs_q <= tdi;
      end
    end else begin : g_bs_chain
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                             bs_q <= '0;
        else if (state == ST_CDR && sel_bs)     bs_q <= BS_CAP;
        else if (do_shift && sel_bs)            bs_q <= {tdi, bs_q[BS_LEN-1:1]};
      end
    end
  endgenerate

  assign dr_so = sel_bs ? bs_q[0] : byp_q;

endmodule

// File: rtl/tapdbg_pinmux.sv
module tapdbg_pinmux
  import tapdbg_pkg::*;
(
  input  logic       trst_n,
  input  logic [2:0] mode_sel,
  input  logic       tms,
  input  logic       tdi,
  input  logic       dbg_tx,
  output logic       tap_rst_n,
  output logic       dbg_si,
  output logic       dbg_brk,
  output logic       pin_dso
);

  logic test_own;
  logic dbg_own;

  always_comb begin
    test_own  = (mode_sel == MODE_TEST);
    dbg_own   = (mode_sel == MODE_DEBUG);
    tap_rst_n = trst_n & test_own;
    dbg_si    = dbg_own ? tdi    : 1'b1;
    dbg_brk   = dbg_own & tms;
    pin_dso   = dbg_own ? dbg_tx : 1'b1;
  end

endmodule

// File: rtl/jtag_dbg_port.sv
module jtag_dbg_port
  import tapdbg_pkg::*;
#(
  parameter int unsigned       BS_LEN = 8,
  parameter logic [BS_LEN-1:0] BS_CAP = 8'hA5
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       pin_tms,
  input  logic       pin_tdi,
  input  logic [2:0] mode_sel,
  input  logic       dbg_tx,
  output logic       pin_tdo,
  output logic       pin_tdo_oe,
  output logic       pin_dso,
  output logic       dbg_si,
  output logic       dbg_brk
);

  logic              tap_rst_n;
  tap_state_e        tap_state;
  logic [IR_W-1:0]   ir_shift;
  logic [IR_W-1:0]   ir_active;
  logic              ir_so;
  logic              byp_q;
  logic [BS_LEN-1:0] bs_q;
  logic              dr_so;
  logic              tdo_q;
  logic              oe_q;

  tapdbg_pinmux u_mux (
    .trst_n    (trst_n),
    .mode_sel  (mode_sel),
    .tms       (pin_tms),
    .tdi       (pin_tdi),
    .dbg_tx    (dbg_tx),
    .tap_rst_n (tap_rst_n),
    .dbg_si    (dbg_si),
    .dbg_brk   (dbg_brk),
    .pin_dso   (pin_dso)
  );

  tapdbg_fsm u_fsm (
    .tck   (tck),
    .rst_n (tap_rst_n),
    .tms   (pin_tms),
    .state (tap_state)
  );

  tapdbg_ir u_ir (
    .tck       (tck),
    .rst_n     (tap_rst_n),
    .state     (tap_state),
    .tdi       (pin_tdi),
    .ir_shift  (ir_shift),
    .ir_active (ir_active),
    .ir_so     (ir_so)
  );

  tapdbg_dr #(.BS_LEN(BS_LEN), .BS_CAP(BS_CAP)) u_dr (
    .tck       (tck),
    .rst_n     (tap_rst_n),
    .state     (tap_state),
    .ir_active (ir_active),
    .tdi       (pin_tdi),
    .byp_q     (byp_q),
    .bs_q      (bs_q),
    .dr_so     (dr_so)
  );

  // Output stage retimed onto the falling edge of the test clock.
  always_ff @(negedge tck or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= (tap_state == ST_HDR) || (tap_state == ST_HIR);
      tdo_q <= (tap_state == ST_HIR) ? ir_so : dr_so;
    end
  end

  assign pin_tdo    = tdo_q;
  assign pin_tdo_oe = oe_q;

endmodule

// File: rtl/jtag_dbg_port_sva.sv
module jtag_dbg_port_sva
  import tapdbg_pkg::*;
#(
  parameter int unsigned BS_LEN = 8
) (
  input logic              tck,
  input logic              trst_n,
  input logic              tap_rst_n,
  input logic [2:0]        mode_sel,
  input logic              pin_tms,
  input logic              pin_tdo,
  input logic              pin_tdo_oe,
  input logic              dbg_brk,
  input tap_state_e        state,
  input logic [IR_W-1:0]   ir_shift,
  input logic              byp,
  input logic [BS_LEN-1:0] bs_chain
);

  logic [2:0] ones_cnt;
  logic       tdo_at_pos;
  logic       oe_at_pos;

  always_ff @(posedge tck or negedge tap_rst_n) begin
    if (!tap_rst_n)           ones_cnt <= 3'd0;
    else if (!pin_tms)        ones_cnt <= 3'd0;
    else if (ones_cnt < 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  always_ff @(posedge tck or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tdo_at_pos <= 1'b0;
      oe_at_pos  <= 1'b0;
    end else begin
      tdo_at_pos <= pin_tdo;
      oe_at_pos  <= pin_tdo_oe;
    end
  end

  AST_TLR_AFTER_FIVE: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (ones_cnt == 3'd5) |-> (state == ST_TLR)); // R2

  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (state == ST_CIR) |=> (ir_shift == IR_CAPTURE)); // R4

  AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (state == ST_CDR) |=> !byp); // R5

  AST_PAUSE_HOLDS: assert property (@(posedge tck) disable iff (!tap_rst_n)
    (state == ST_PDR) |=> ($stable(bs_chain) && $stable(byp))); // R7

  AST_TDO_FALLING: assert property (@(negedge tck) disable iff (!tap_rst_n)
    (pin_tdo == tdo_at_pos) && (pin_tdo_oe == oe_at_pos)); // R8

  AST_OE_DEBUG: assert property (@(posedge tck) disable iff (!trst_n)
    (mode_sel == MODE_DEBUG) |-> !pin_tdo_oe); // R10

  AST_BRK_TEST: assert property (@(posedge tck) disable iff (!trst_n)
    (mode_sel == MODE_TEST) |-> !dbg_brk); // R11

  AST_OE_PARKED: assert property (@(posedge tck) disable iff (!trst_n)
    (mode_sel != MODE_TEST && mode_sel != MODE_DEBUG) |-> (!pin_tdo_oe && !dbg_brk)); // R12

endmodule

bind jtag_dbg_port jtag_dbg_port_sva #(.BS_LEN(BS_LEN)) u_sva (
  .tck        (tck),
  .trst_n     (trst_n),
  .tap_rst_n  (tap_rst_n),
  .mode_sel   (mode_sel),
  .pin_tms    (pin_tms),
  .pin_tdo    (pin_tdo),
  .pin_tdo_oe (pin_tdo_oe),
  .dbg_brk    (dbg_brk),
  .state      (tap_state),
  .ir_shift   (ir_shift),
  .byp        (byp_q),
  .bs_chain   (bs_q)
);

// File: tb/jtag_dbg_port_test.sv
module jtag_dbg_port_test;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b1;
  logic [2:0] mode = 3'b000;
  logic       dbg_tx = 1'b1;
  logic       pin_tdo, pin_tdo_oe, pin_dso, dbg_si, dbg_brk;

  int checks = 0;
  int fails  = 0;

  logic  exp_q[$];
  string tag_q[$];
  logic [63:0] mdl;
  int          mlen;

  jtag_dbg_port uut (
    .tck(tck), .trst_n(trst_n), .pin_tms(tms), .pin_tdi(tdi),
    .mode_sel(mode), .dbg_tx(dbg_tx), .pin_tdo(pin_tdo),
    .pin_tdo_oe(pin_tdo_oe), .pin_dso(pin_dso), .dbg_si(dbg_si),
    .dbg_brk(dbg_brk)
  );

  always #4 tck = ~tck;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    @(posedge tck);
  endtask

  task automatic push(input string tag);
    exp_q.push_back(mdl[0]);
    tag_q.push_back(tag);
  endtask

  task automatic mshift(input logic d);
    mdl = mdl >> 1;
    mdl[mlen-1] = d;
  endtask

  // From Run-Test/Idle: load an instruction (R1, R4), return to Run-Test/Idle.
  task automatic ir_scan(input logic [3:0] code);
    tick(1, 1); tick(1, 1); tick(0, 1); tick(0, 1);
    mdl = 64'h1; mlen = 4;
    push("R4");
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i]);
      mshift(code[i]);
      if (i != 3) push("R4");
    end
    tick(1, 1); tick(0, 1);
  endtask

  // From Run-Test/Idle: full data scan, n bits shifted.
  task automatic dr_scan(input logic [63:0] din, input int n, input int len,
                         input logic [63:0] cap, input string tag);
    tick(1, 1); tick(0, 1); tick(0, 1);
    mdl = cap; mlen = len;
    push(tag);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      mshift(din[i]);
      if (i != n - 1) push(tag);
    end
    tick(1, 1); tick(0, 1);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Monitor: pops expected serial bits while the output is enabled.
  initial begin
    forever begin
      @(negedge tck);
      #2;
      if (pin_tdo_oe === 1'b1) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9 output enabled unexpectedly actual=1 expected=0");
        end else begin
          logic  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (pin_tdo !== e) begin
            fails++;
            $display("FAIL %s tdo actual=%b expected=%b", t, pin_tdo, e);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // Reset state (R3, R11)
    #10;
    chk("R3 oe in reset", pin_tdo_oe, 1'b0);
    chk("R11 dbg_brk idle", dbg_brk, 1'b0);
    chk("R11 dbg_si idle", dbg_si, 1'b1);
    chk("R11 pin_dso idle", pin_dso, 1'b1);
    @(negedge tck); #1 trst_n = 1'b1;
    tick(0, 1);

    // R1 R3 R5: after reset the bypass path is selected
    dr_scan(64'hB2, 8, 1, 64'h0, "R5");

    // R4 R6: SAMPLE code selects the boundary chain; check R8 half-cycle timing
    ir_scan(4'b0010);
    tick(1, 1); tick(0, 1); tick(0, 1);
    #1 chk("R8 oe still low after rising edge", pin_tdo_oe, 1'b0);
    mdl = 64'hA5; mlen = 8;
    push("R6");
    for (int i = 0; i < 12; i++) begin
      logic b;
      b = ((12'h5C3 >> i) & 1) != 0;
      tick(i == 11, b);
      mshift(b);
      if (i != 11) push("R6");
    end
    #1 chk("R8 oe still high after exit edge", pin_tdo_oe, 1'b1);
    tick(1, 1); tick(0, 1);

    // R6: an unlisted code selects bypass
    ir_scan(4'b0111);
    dr_scan(64'h5, 3, 1, 64'h0, "R6");

    // R7: EXTEST chain with a pause in the middle
    ir_scan(4'b0000);
    tick(1, 1); tick(0, 1); tick(0, 1);
    mdl = 64'hA5; mlen = 8;
    push("R7");
    tick(0, 1); mshift(1); push("R7");
    tick(0, 0); mshift(0); push("R7");
    tick(1, 1); mshift(1);
    tick(0, 0); tick(0, 0); tick(0, 0); tick(1, 0);
    tick(0, 1);
    push("R7");
    tick(0, 0); mshift(0); push("R7");
    tick(0, 1); mshift(1); push("R7");
    tick(0, 1); mshift(1); push("R7");
    tick(1, 0); mshift(0);
    tick(1, 1); tick(0, 1);

    // R2: escape from Shift-DR with five high edges
    ir_scan(4'b0010);
    tick(1, 1); tick(0, 1); tick(0, 1);
    mdl = 64'hA5; mlen = 8;
    push("R2");
    for (int i = 0; i < 5; i++) tick(1, 1);
    tick(0, 1);
    dr_scan(64'h6, 4, 1, 64'h0, "R2");

    // R3: asynchronous reset in the middle of a shift
    ir_scan(4'b0010);
    tick(1, 1); tick(0, 1); tick(0, 1);
    mdl = 64'hA5; mlen = 8;
    push("R3");
    @(negedge tck); #3 trst_n = 1'b0;
    #1 chk("R3 oe drops without a clock edge", pin_tdo_oe, 1'b0);
    tms = 1'b1;
    @(negedge tck); #1 trst_n = 1'b1;
    tick(0, 1);
    dr_scan(64'h9, 4, 1, 64'h0, "R3");

    // R10: debug ownership
    ir_scan(4'b0010);
    @(negedge tck); #1 mode = 3'b001; tms = 1'b0;
    #1 chk("R10 brk low", dbg_brk, 1'b0);
    chk("R10 oe low", pin_tdo_oe, 1'b0);
    tms = 1'b1; #1 chk("R10 brk follows tms", dbg_brk, 1'b1);
    tdi = 1'b0; #1 chk("R10 si follows tdi low", dbg_si, 1'b0);
    tdi = 1'b1; #1 chk("R10 si follows tdi high", dbg_si, 1'b1);
    dbg_tx = 1'b0; #1 chk("R10 dso follows tx low", pin_dso, 1'b0);
    dbg_tx = 1'b1; #1 chk("R10 dso follows tx high", pin_dso, 1'b1);
    tick(0, 1); tick(1, 1); tick(0, 1); tick(0, 1); tick(0, 0); tick(0, 1);
    @(negedge tck); #1 mode = 3'b000; tms = 1'b1; tdi = 1'b0; dbg_tx = 1'b0;
    #1 chk("R11 brk idle in test mode", dbg_brk, 1'b0);
    chk("R11 si idle in test mode", dbg_si, 1'b1);
    chk("R11 dso idle in test mode", pin_dso, 1'b1);
    tdi = 1'b1; dbg_tx = 1'b1;
    tick(0, 1);
    dr_scan(64'hA, 4, 1, 64'h0, "R10");

    // R12: parked code
    ir_scan(4'b0010);
    @(negedge tck); #1 mode = 3'b101; tms = 1'b1; tdi = 1'b0; dbg_tx = 1'b0;
    #1 chk("R12 brk idle", dbg_brk, 1'b0);
    chk("R12 si idle", dbg_si, 1'b1);
    chk("R12 dso idle", pin_dso, 1'b1);
    chk("R12 oe low", pin_tdo_oe, 1'b0);
    tdi = 1'b1; dbg_tx = 1'b1;
    tick(0, 1); tick(1, 1); tick(0, 1); tick(0, 1); tick(0, 1);
    @(negedge tck); #1 mode = 3'b000; tms = 1'b1;
    tick(0, 1);
    dr_scan(64'h3, 3, 1, 64'h0, "R12");

    repeat (3) @(posedge tck);
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 missing output bits actual=%0d expected=0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule